// File: doc/BRIEF.md
# Flattened Sequential Pattern Matcher-Counter

This block counts how many input sequences contain one candidate sequential pattern, where the pattern is an ordered list of itemsets. The input is a stream of 8-bit symbols. Item codes run from 0 to 252. A separate code marks the end of an itemset, another marks the border between sequences, and a final code ends the stream. Items inside every input itemset and every candidate itemset are sorted in ascending order. Because of this ordering, containment of a set reduces to ordered matching with gaps.

The candidate is held as a fixed chain of eight pattern slots. Item codes and itemset delimiters fill the chain, and an entry index selects the first used slot. One chain therefore serves every grouping of itemsets whose encoded length fits. Each slot has a waiting state that holds its position across input symbols that do not advance it. The first slot of a candidate itemset may wait across input itemsets. Any other slot waits only inside one input itemset.

A matched input sequence increments a support counter once, when its closing sequence delimiter arrives. The counter is built from 12-bit stages in cascade. When the end-of-data code arrives, the block reports whether the support count reaches a programmed threshold. It then clears the count for the next stream.

Top module: `seq_pattern_counter`

## Requirements
- R1: Symbol codes are fixed. Items are 0..252, 253 ends an itemset, 254 separates sequences and 255 ends the stream. A configuration write to address j (0..7) loads slot j with `cfg_data_i[7:0]`. Address 8 loads the entry index from `cfg_data_i[2:0]`. Address 9 loads the 16-bit threshold.
- R2: Symbols that arrive before the first 254 of a stream never start a match.
- R3: A candidate itemset matches an input itemset that is a superset of it. Extra input items may come before, between or after the candidate items.
- R4: Candidate itemsets must be found in order, each in a different input itemset, and any number of unrelated itemsets may lie between them. Two candidate itemsets cannot both be satisfied by one input itemset.
- R5: A sequence is counted only when its closing 254 arrives. A partial sequence that is ended directly by 255 is not counted.
- R6: Each input sequence adds at most one to the count, however often the pattern occurs inside it.
- R7: With entry index e, the pattern is slots e..7. The contents of slots below e have no effect.
- R8: `report_o` is high for exactly the one cycle after the cycle in which 255 is accepted. In that same cycle `support_o` takes the final count and `frequent_o` becomes 1 when that count is greater than or equal to the threshold. Both outputs hold their values until the next report.
- R9: The count returns to zero when the report is made, so each stream counts from zero.
- R10: The count is not limited to 4095. The first 12-bit stage carries into the next stage, so a threshold of 4096 is reached by 4096 matching sequences.
- R11: A symbol with `sym_valid_i` low has no effect.
- R12: After reset `report_o` and `frequent_o` are 0 and `support_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration address: slots 0..7, entry 8, threshold 9 |
| cfg_data_i | input | 16 | Configuration write data |
| sym_valid_i | input | 1 | Stream symbol valid |
| sym_i | input | 8 | Stream symbol |
| report_o | output | 1 | One-cycle pulse after end of stream |
| frequent_o | output | 1 | Final count is at least the threshold |
| support_o | output | 24 | Final count of matching sequences |

## Verification
The main sweep is exhaustive over a three-item alphabet. Every candidate made of one or two nonempty itemsets is run against a stream that holds every input sequence of one or two nonempty itemsets. The bench compares the result with a set-containment count computed in the bench. This separates superset matching inside one input itemset from ordered matching across input itemsets, and it catches a pattern that is wrongly satisfied by a single itemset. The unused low slots are filled with an item that never occurs, so an ignored entry index shows up as a lost count. Directed streams then cover the remaining cases:
- a stream with no leading delimiter,
- a sequence left open at the end of data,
- repeated occurrences of the pattern in one sequence,
- unrelated itemsets between the candidate itemsets,
- symbols presented with valid low,
- support counts on either side of the carry into the second counter stage.

// File: rtl/seq_match_pkg.sv
package seq_match_pkg;
  localparam int unsigned SYM_W   = 8;
  localparam int unsigned STAGE_W = 12;
  localparam logic [SYM_W-1:0] SYM_SET_DELIM = 8'd253;
  localparam logic [SYM_W-1:0] SYM_SEQ_DELIM = 8'd254;
  localparam logic [SYM_W-1:0] SYM_END       = 8'd255;

  function automatic int unsigned cnt_width(int unsigned thr_w);
    return ((thr_w + STAGE_W - 1) / STAGE_W) * STAGE_W;
  endfunction
endpackage

// File: rtl/seq_slot_chain.sv
module seq_slot_chain
  import seq_match_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [SYM_W-1:0]             sym_i,
  input  logic [SLOTS-1:0][SYM_W-1:0]  slot_sym_i,
  input  logic [IDX_W-1:0]             entry_i,
  output logic                         hit_o,
  output logic [SLOTS-1:0]             wait_o
);
  logic [SLOTS-1:0] wait_q, wait_step, adv, keep, first_set;
  logic             done_q;
  logic             seq_close, stream_end;

  assign seq_close  = valid_i && (sym_i == SYM_SEQ_DELIM);
  assign stream_end = valid_i && (sym_i == SYM_END);
  assign hit_o      = seq_close && done_q;
  assign wait_o     = wait_q;

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      // first slot of a candidate itemset may wait across input itemsets
      first_set[j] = (IDX_W'(j) == entry_i) ||
                     ((j > 0) && (slot_sym_i[(j > 0) ? j-1 : 0] == SYM_SET_DELIM));
      adv[j]       = wait_q[j] && (sym_i == slot_sym_i[j]);
      keep[j]      = wait_q[j] && (first_set[j] || (sym_i != SYM_SET_DELIM));
    end
    wait_step = keep | {adv[SLOTS-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      done_q <= 1'b0;
    end else if (valid_i) begin
      if (seq_close) begin
        wait_q <= SLOTS'(1) << entry_i;
        done_q <= 1'b0;
      end else if (stream_end) begin
        wait_q <= '0;
        done_q <= 1'b0;
      end else begin
        wait_q <= wait_step;
        done_q <= done_q | adv[SLOTS-1];
      end
    end
  end
endmodule

// File: rtl/seq_support_ctr.sv
module seq_support_ctr
  import seq_match_pkg::*;
#(
  parameter int unsigned THR_W = 16,
  localparam int unsigned NSTAGE = (THR_W + STAGE_W - 1) / STAGE_W,
  localparam int unsigned CNT_W  = NSTAGE * STAGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [NSTAGE:0] carry;
  assign carry[0] = inc_i;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic [STAGE_W-1:0] q_q;
    assign carry[s+1] = carry[s] && (&q_q);
    assign count_o[s*STAGE_W +: STAGE_W] = q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_q <= '0;
      else if (clr_i)    q_q <= '0;
      else if (carry[s]) q_q <= q_q + STAGE_W'(1);
    end
  end
endmodule

// File: rtl/seq_pattern_counter.sv
module seq_pattern_counter
  import seq_match_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned THR_W = 16,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned ADDR_W = $clog2(SLOTS + 2),
  localparam int unsigned CNT_W  = cnt_width(THR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [THR_W-1:0]  cfg_data_i,
  input  logic              sym_valid_i,
  input  logic [SYM_W-1:0]  sym_i,
  output logic              report_o,
  output logic              frequent_o,
  output logic [CNT_W-1:0]  support_o
);
  logic [SLOTS-1:0][SYM_W-1:0] slot_q;
  logic [IDX_W-1:0]            entry_q;
  logic [THR_W-1:0]            thr_q;
  logic [CNT_W-1:0]            live_count;
  logic [SLOTS-1:0]            slot_wait;
  logic                        seq_hit, eod;

  assign eod = sym_valid_i && (sym_i == SYM_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= {SLOTS{SYM_END}};
      entry_q <= '0;
      thr_q   <= '0;
    end else if (cfg_we_i) begin
      for (int j = 0; j < SLOTS; j++)
        if (cfg_addr_i == ADDR_W'(j)) slot_q[j] <= cfg_data_i[SYM_W-1:0];
      if (cfg_addr_i == ADDR_W'(SLOTS))     entry_q <= cfg_data_i[IDX_W-1:0];
      if (cfg_addr_i == ADDR_W'(SLOTS + 1)) thr_q   <= cfg_data_i;
    end
  end

  seq_slot_chain #(.SLOTS(SLOTS)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sym_valid_i),
    .sym_i      (sym_i),
    .slot_sym_i (slot_q),
    .entry_i    (entry_q),
    .hit_o      (seq_hit),
    .wait_o     (slot_wait)
  );

  seq_support_ctr #(.THR_W(THR_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (eod),
    .inc_i   (seq_hit),
    .count_o (live_count)
  );

  // deferred report: decided only when the stream ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      report_o   <= 1'b0;
      frequent_o <= 1'b0;
      support_o  <= '0;
    end else begin
      report_o <= eod;
      if (eod) begin
        frequent_o <= (live_count >= CNT_W'(thr_q));
        support_o  <= live_count;
      end
    end
  end
endmodule

// File: rtl/seq_pattern_counter_chk.sv
module seq_pattern_counter_chk #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sym_valid_i,
  input logic [7:0]       sym_i,
  input logic             report_o,
  input logic             frequent_o,
  input logic [CNT_W-1:0] support_o,
  input logic [CNT_W-1:0] count_i,
  input logic             hit_i,
  input logic [SLOTS-1:0] wait_i,
  input logic [IDX_W-1:0] entry_i
);
  AST_REPORT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o |=> !report_o); // R8
  AST_REPORT_FOLLOWS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o |-> ($past(sym_valid_i) && $past(sym_i) == 8'd255)); // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !report_o |-> ($stable(support_o) && $stable(frequent_o))); // R8
  AST_HIT_ON_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (sym_valid_i && sym_i == 8'd254)); // R5
  AST_COUNT_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != $past(count_i)) |-> (count_i == $past(count_i) + CNT_W'(1) || count_i == '0)); // R6
  AST_COUNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_o |-> (count_i == '0)); // R9
  AST_NO_WAIT_BELOW_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i & ((SLOTS'(1) << entry_i) - SLOTS'(1))) == '0); // R7
endmodule

bind seq_pattern_counter seq_pattern_counter_chk #(
  .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .sym_i       (sym_i),
  .report_o    (report_o),
  .frequent_o  (frequent_o),
  .support_o   (support_o),
  .count_i     (live_count),
  .hit_i       (seq_hit),
  .wait_i      (slot_wait),
  .entry_i     (entry_q)
);

// File: tb/seq_pattern_counter_tb_top.sv
`timescale 1ns/1ps
module seq_pattern_counter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic        sym_valid_i = 1'b0;
  logic [7:0]  sym_i = '0;
  logic        report_o, frequent_o;
  logic [23:0] support_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  seq_pattern_counter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_data_i(cfg_data_i), .sym_valid_i(sym_valid_i), .sym_i(sym_i),
    .report_o(report_o), .frequent_o(frequent_o), .support_o(support_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic cfg(input int addr, input int data);
    @(negedge clk_i);
    sym_valid_i = 1'b0;
    cfg_we_i = 1'b1; cfg_addr_i = 4'(addr); cfg_data_i = 16'(data);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic send(input int s);
    @(negedge clk_i);
    sym_valid_i = 1'b1; sym_i = 8'(s);
  endtask

  // ends the stream and checks the report window
  task automatic finish_stream(input string req, input int exp_sup, input int exp_freq);
    send(255);
    @(negedge clk_i);
    sym_valid_i = 1'b0;
    check("R8 report pulse", int'(report_o), 1);
    check(req, int'(support_o), exp_sup);
    check("R8 frequent", int'(frequent_o), exp_freq);
    @(negedge clk_i);
    check("R8 report low", int'(report_o), 0);
  endtask

  // sequence/pattern index n -> itemset masks over items {1,2,3}
  function automatic void decode(input int n, output int len, output int m0, output int m1);
    if (n < 7) begin len = 1; m0 = n + 1; m1 = 0; end
    else begin len = 2; m0 = (n - 7) / 7 + 1; m1 = (n - 7) % 7 + 1; end
  endfunction

  function automatic int contains(input int s, input int p);
    int sl, s0, s1, pl, p0, p1, pi;
    int sa[2];
    int pa[2];
    decode(s, sl, s0, s1);
    decode(p, pl, p0, p1);
    sa[0] = s0; sa[1] = s1; pa[0] = p0; pa[1] = p1;
    pi = 0;
    for (int k = 0; k < sl; k++)
      if (pi < pl && (sa[k] & pa[pi]) == pa[pi]) pi++;
    return (pi == pl) ? 1 : 0;
  endfunction

  task automatic send_set(input int m);
    for (int b = 0; b < 3; b++)
      if (m[b]) send(b + 1);
  endtask

  task automatic load_pattern(input int p, input int thr);
    int pl, p0, p1, len, entry;
    int sl[8];
    decode(p, pl, p0, p1);
    len = 0;
    for (int b = 0; b < 3; b++) if (p0[b]) begin sl[len] = b + 1; len++; end
    if (pl == 2) begin
      sl[len] = 253; len++;
      for (int b = 0; b < 3; b++) if (p1[b]) begin sl[len] = b + 1; len++; end
    end
    entry = 8 - len;
    for (int j = 0; j < 8; j++)
      cfg(j, (j < entry) ? 9 : sl[j - entry]);
    cfg(8, entry);
    cfg(9, thr);
  endtask

  initial begin
    #(150000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R12 report", int'(report_o), 0);
    check("R12 frequent", int'(frequent_o), 0);
    check("R12 support", int'(support_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // pattern {1}: slot7 = 1, entry 7 (R1)
    cfg(7, 1); cfg(8, 7); cfg(9, 1);
    send(1); send(254);
    finish_stream("R2 no start before delimiter", 0, 0);
    send(254); send(1);
    finish_stream("R5 open sequence not counted", 0, 0);
    send(254); send(1); send(253); send(1); send(253); send(1); send(254);
    finish_stream("R6 once per sequence", 1, 1);
    send(254);
    @(negedge clk_i); sym_valid_i = 1'b0; sym_i = 8'd1;
    send(254);
    finish_stream("R11 invalid symbol ignored", 0, 0);

    // pattern {1}{3}, unrelated itemsets in between
    cfg(5, 1); cfg(6, 253); cfg(7, 3); cfg(8, 5); cfg(9, 1);
    send(254); send(2); send(253); send(1); send(253); send(2);
    send(253); send(2); send(3); send(254);
    finish_stream("R4 gap itemsets", 1, 1);

    // exhaustive sweep over patterns and sequences
    for (int p = 0; p < 56; p++) begin
      int exp, thr, pl, p0, p1;
      exp = 0;
      for (int s = 0; s < 56; s++) exp += contains(s, p);
      thr = (p % 2 == 1) ? exp + 1 : exp;
      load_pattern(p, thr);
      for (int s = 0; s < 56; s++) begin
        int sl, s0, s1;
        decode(s, sl, s0, s1);
        send(254);
        send_set(s0);
        if (sl == 2) begin send(253); send_set(s1); end
      end
      send(254);
      decode(p, pl, p0, p1);
      // R9: each stream starts from zero; R7: low slots hold item 9
      finish_stream((pl == 1) ? "R3 superset match" : "R4 ordered itemsets",
                    exp, (p % 2 == 1) ? 0 : 1);
    end

    // carry into the second counter stage
    cfg(7, 7); cfg(8, 7); cfg(9, 4096);
    for (int i = 0; i < 4096; i++) begin send(254); send(7); end
    send(254);
    finish_stream("R10 count 4096", 4096, 1);
    cfg(9, 4097);
    for (int i = 0; i < 4096; i++) begin send(254); send(7); end
    send(254);
    finish_stream("R10 below threshold 4097", 4096, 0);

    summary();
  end
endmodule